// File: doc/BRIEF.md
# DRAM Multipurpose Register Mode Controller

This block sits inside a DDR3-style memory device and tracks the multipurpose-register (MPR) read mode. It watches the decoded command stream and keeps a mode flag and a two-bit location select, both loaded by a mode-register write to register 3. While the mode is off, read bursts carry the array's data unchanged and writes reach the array. While the mode is on, every read or read-with-auto-precharge returns a fixed calibration pattern instead of array data. The pattern is placed on the prime DQ lane or lanes, and every other lane is held low.

Entry into the mode is only legal when all banks are precharged and the precharge time has elapsed. While the mode is active, only reads, an exit write to register 3 and the RESET command are accepted. Any other command is rejected. A rejected command raises a one-cycle error pulse and changes nothing else. The device width is fixed at elaboration and decides which lanes carry the pattern.

Top module: `mpr_mode_ctrl`

## Requirements
- R1: While reset is held, and until the first command after it, `mpr_active`, `cmd_err` and `rd_valid` are 0 and `dq_out` is all zeros.
- R2: A mode-register write with `mr_addr`=3 and `mr_bits[2]`=1, issued while the mode is off and with `banks_idle`=1 and `trp_met`=1, sets `mpr_active` on the next clock and stores `mr_bits[1:0]` as the location select.
- R3: The same entry write issued while `banks_idle` or `trp_met` is 0 leaves `mpr_active` at 0 and raises `cmd_err` for exactly the next cycle.
- R4: While the mode is on, the following commands pulse `cmd_err` for one cycle and leave the mode, the select and any running burst unchanged: WRITE, ACTIVATE, PRECHARGE, REFRESH, POWER-DOWN, SELF-REFRESH, a mode-register write to any register other than 3, and a write to register 3 with bit 2 set. A WRITE rejected this way never asserts `array_wr_en`.
- R5: READ (`cmd_code` 2) and RDAP (`cmd_code` 3) start an 8-beat burst. `rd_valid` is high from the next cycle for 8 cycles, one beat per cycle. In the mode with select 00, beat k carries k mod 2 on the prime lanes (0,1,0,1,...), and all other lanes are 0.
- R6: In the mode with select 01, 10 or 11, every lane of a read burst is 0.
- R7: With the mode off, `dq_out` equals `array_dq` on every beat of a read burst. Outside a burst, `dq_out` is 0.
- R8: With the mode off, WRITE (`cmd_code` 4) asserts `array_wr_en` in the cycle it is presented. No command raises `cmd_err` in this state, except a blocked entry (R3).
- R9: RESET (`cmd_code` 10) is accepted in any state. It clears the mode, the select and any running burst on the next clock, without raising `cmd_err`.
- R10: A write to register 3 with bit 2 clear leaves the mode on the next clock, whatever the values of `banks_idle` and `trp_met`.
- R11: Reads repeat without re-arming. A read arriving during a burst restarts the burst at beat 0.
- R12: A burst keeps the data source and select that were in force when its read was accepted, even if the mode is left partway through the burst.
- R13: With `DQ_W`=16, the prime lanes are DQ0 and DQ8. With `DQ_W` of 4 or 8, the only prime lane is DQ0.

Command codes: 0 NOP, 1 mode-register write, 2 READ, 3 RDAP, 4 WRITE, 5 ACTIVATE, 6 PRECHARGE, 7 REFRESH, 8 POWER-DOWN, 9 SELF-REFRESH, 10 RESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_code | input | 4 | Command code |
| mr_addr | input | 2 | Target mode register of a mode-register write |
| mr_bits | input | 3 | Bits 2:0 of the mode-register value (bit 2 = enable, bits 1:0 = select) |
| banks_idle | input | 1 | All banks are precharged |
| trp_met | input | 1 | Precharge time has elapsed |
| array_dq | input | DQ_W | Read data from the array for the current beat |
| dq_out | output | DQ_W | Read data lanes |
| rd_valid | output | 1 | A burst beat is on `dq_out` |
| mpr_active | output | 1 | The MPR mode is on |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |
| array_wr_en | output | 1 | A write is passed to the array |

## Verification
Two functions can fall in the same cycle: a burst streaming pattern beats, and a new command being judged. A rejected command, an exit write or a restarting read can each land on a middle beat of a burst. The bench provokes this with directed sequences that issue such commands on beats 2 to 5. Its random phase does the same by mixing reads with all other commands without waiting for bursts to end. A cycle model written from the requirements predicts `cmd_err`, `mpr_active`, `rd_valid` and every lane of `dq_out` in every cycle. A mismatch therefore shows whether the error pulse disturbed the burst, or whether the burst followed a mode change it should have ignored.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_MRS   = 4'd1,
    CMD_RD    = 4'd2,
    CMD_RDAP  = 4'd3,
    CMD_WR    = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_REF   = 4'd7,
    CMD_PDE   = 4'd8,
    CMD_SRE   = 4'd9,
    CMD_RESET = 4'd10
  } cmd_e;

  localparam int unsigned MR_ADDR_W = 2;
  localparam int unsigned LOC_W     = 2;
endpackage

// File: rtl/mpr_mode_regs.sv
module mpr_mode_regs
  import mpr_pkg::*;
#(
  parameter int unsigned TARGET_MR = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [3:0]           cmd_code,
  input  logic [MR_ADDR_W-1:0] mr_addr,
  input  logic [2:0]           mr_bits,
  input  logic                 banks_idle,
  input  logic                 trp_met,
  output logic                 on_q,
  output logic [LOC_W-1:0]     loc_q,
  output logic                 err_q,
  output logic                 rd_start,
  output logic                 kill,
  output logic                 wr_ok
);
  cmd_e             cmd;
  logic             is_rd, is_tgt_mr, may_enter;
  logic             on_d, err_d, upd_en;
  logic [LOC_W-1:0] loc_d;

  assign cmd       = cmd_e'(cmd_code);
  assign is_rd     = (cmd == CMD_RD) || (cmd == CMD_RDAP);
  assign is_tgt_mr = (cmd == CMD_MRS) && (mr_addr == MR_ADDR_W'(TARGET_MR));
  assign may_enter = banks_idle && trp_met;
  assign rd_start  = cmd_valid && is_rd;
  assign kill      = cmd_valid && (cmd == CMD_RESET);
  assign wr_ok     = cmd_valid && (cmd == CMD_WR) && !on_q;
  assign upd_en    = cmd_valid;

  always_comb begin
    on_d  = on_q;
    loc_d = loc_q;
    err_d = 1'b0;
    if (cmd_valid) begin
      if (cmd == CMD_RESET) begin
        on_d  = 1'b0;
        loc_d = '0;
      end else if (is_tgt_mr) begin
        if (!on_q) begin
          if (mr_bits[2] && !may_enter) begin
            err_d = 1'b1;
          end else begin
            on_d  = mr_bits[2];
            loc_d = mr_bits[1:0];
          end
        end else if (mr_bits[2]) begin
          err_d = 1'b1;
        end else begin
          on_d  = 1'b0;
          loc_d = mr_bits[1:0];
        end
      end else if (on_q && !is_rd && (cmd != CMD_NOP)) begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      loc_q <= '0;
    end else if (upd_en) begin
      on_q  <= on_d;
      loc_q <= loc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assert_entry_needs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_tgt_mr && mr_bits[2] && !on_q && !(banks_idle && trp_met))
      |=> (!on_q && err_q));

  assert_entry_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_tgt_mr && mr_bits[2] && !on_q && banks_idle && trp_met)
      |=> (on_q && !err_q && loc_q == $past(mr_bits[1:0])));

  assert_reject_keeps_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && on_q && !is_rd && (cmd != CMD_NOP) && (cmd != CMD_RESET)
      && !(is_tgt_mr && !mr_bits[2]))
      |=> (err_q && on_q && loc_q == $past(loc_q)));

  assert_reset_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!on_q && !err_q && loc_q == '0));

  assert_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_tgt_mr && !mr_bits[2]) |=> !on_q);
endmodule

// File: rtl/mpr_burst_seq.sv
module mpr_burst_seq
  import mpr_pkg::*;
#(
  parameter int unsigned BURST_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             kill,
  input  logic             src_mpr_in,
  input  logic [LOC_W-1:0] loc_in,
  output logic             act_q,
  output logic             src_mpr_q,
  output logic             pat_bit
);
  localparam int unsigned CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_d, src_d, cap_en, run_en;
  logic [LOC_W-1:0] loc_q, loc_d;

  assign cap_en = start && !kill;
  assign run_en = cap_en || kill || act_q;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    src_d = src_mpr_q;
    loc_d = loc_q;
    if (kill) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (cap_en) begin
      act_d = 1'b1;
      cnt_d = '0;
      src_d = src_mpr_in;
      loc_d = loc_in;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      cnt_q     <= '0;
      src_mpr_q <= 1'b0;
      loc_q     <= '0;
    end else if (run_en) begin
      act_q     <= act_d;
      cnt_q     <= cnt_d;
      src_mpr_q <= src_d;
      loc_q     <= loc_d;
    end
  end

  assign pat_bit = act_q && src_mpr_q && (loc_q == '0) && cnt_q[0];

  assert_burst_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !kill) |=> (act_q && cnt_q == '0));

  assert_burst_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q == LAST && !start) |=> !act_q);

  assert_src_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !start && !kill && cnt_q != LAST) |=> $stable(src_mpr_q));
endmodule

// File: rtl/mpr_lane_map.sv
module mpr_lane_map #(
  parameter int unsigned DQ_W = 16
) (
  input  logic            burst_on,
  input  logic            use_mpr,
  input  logic            pat_bit,
  input  logic [DQ_W-1:0] array_dq,
  output logic [DQ_W-1:0] dq
);
  localparam int unsigned LANE_GROUP = 8;

  for (genvar i = 0; i < DQ_W; i++) begin : g_lane
    if ((i % LANE_GROUP) == 0) begin : g_prime
      assign dq[i] = burst_on && (use_mpr ? pat_bit : array_dq[i]);
    end else begin : g_other
      assign dq[i] = burst_on && !use_mpr && array_dq[i];
    end
  end

  always_comb begin
    assert_lane_quiet_R7: assert (burst_on || dq == '0);
  end
endmodule

// File: rtl/mpr_mode_ctrl.sv
module mpr_mode_ctrl
  import mpr_pkg::*;
#(
  parameter int unsigned DQ_W      = 16,
  parameter int unsigned BURST_LEN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_code,
  input  logic [1:0]      mr_addr,
  input  logic [2:0]      mr_bits,
  input  logic            banks_idle,
  input  logic            trp_met,
  input  logic [DQ_W-1:0] array_dq,
  output logic [DQ_W-1:0] dq_out,
  output logic            rd_valid,
  output logic            mpr_active,
  output logic            cmd_err,
  output logic            array_wr_en
);
  logic             rst_meta_n, rst_sync_n;
  logic             on_q, err_q, rd_start, kill, wr_ok;
  logic             act_q, src_mpr_q, pat_bit;
  logic [LOC_W-1:0] loc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  mpr_mode_regs #(.TARGET_MR(3)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .mr_addr    (mr_addr),
    .mr_bits    (mr_bits),
    .banks_idle (banks_idle),
    .trp_met    (trp_met),
    .on_q       (on_q),
    .loc_q      (loc_q),
    .err_q      (err_q),
    .rd_start   (rd_start),
    .kill       (kill),
    .wr_ok      (wr_ok)
  );

  mpr_burst_seq #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (rd_start),
    .kill       (kill),
    .src_mpr_in (on_q),
    .loc_in     (loc_q),
    .act_q      (act_q),
    .src_mpr_q  (src_mpr_q),
    .pat_bit    (pat_bit)
  );

  mpr_lane_map #(.DQ_W(DQ_W)) u_lanes (
    .burst_on (act_q),
    .use_mpr  (src_mpr_q),
    .pat_bit  (pat_bit),
    .array_dq (array_dq),
    .dq       (dq_out)
  );

  assign rd_valid    = act_q;
  assign mpr_active  = on_q;
  assign cmd_err     = err_q;
  assign array_wr_en = wr_ok;

  always_comb begin
    assert_no_array_write_in_mode_R4: assert (!(array_wr_en && mpr_active));
  end
endmodule

// File: tb/mpr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module mpr_mode_ctrl_tb_top;
  localparam int DQ_W = 16;
  localparam int BL   = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cmd_valid;
  logic [3:0]      cmd_code;
  logic [1:0]      mr_addr;
  logic [2:0]      mr_bits;
  logic            banks_idle, trp_met;
  logic [DQ_W-1:0] array_dq, dq_out;
  logic            rd_valid, mpr_active, cmd_err, array_wr_en;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  bit       m_on, m_err, m_act, m_src;
  bit [1:0] m_sel, m_loc;
  int       m_cnt;

  always #5 clk = ~clk;

  mpr_mode_ctrl #(.DQ_W(DQ_W), .BURST_LEN(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .mr_addr(mr_addr), .mr_bits(mr_bits), .banks_idle(banks_idle),
    .trp_met(trp_met), .array_dq(array_dq), .dq_out(dq_out),
    .rd_valid(rd_valid), .mpr_active(mpr_active), .cmd_err(cmd_err),
    .array_wr_en(array_wr_en)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DQ_W-1:0] exp_dq(input logic [DQ_W-1:0] arr);
    logic [DQ_W-1:0] v = '0;
    if (!m_act) return '0;
    if (!m_src) return arr;
    for (int i = 0; i < DQ_W; i += 8)
      v[i] = (m_loc == 2'b00) ? m_cnt[0] : 1'b0;
    return v;
  endfunction

  function automatic bit exp_wr(input logic [3:0] c);
    return (c == 4'd4) && !m_on;
  endfunction

  task automatic model(input logic [3:0] c, input logic [1:0] a, input logic [2:0] b,
                       input bit idle, input bit trp);
    bit st = 1'b0, kl = 1'b0, was_on = m_on;
    m_err = 1'b0;
    if (c == 4'd10) begin
      m_on = 0; m_sel = 0; kl = 1;
    end else if (c == 4'd1 && a == 2'd3) begin
      if (!was_on) begin
        if (b[2] && !(idle && trp)) m_err = 1;
        else begin m_on = b[2]; m_sel = b[1:0]; end
      end else if (b[2]) m_err = 1;
      else begin m_on = 0; m_sel = b[1:0]; end
    end else if (c == 4'd2 || c == 4'd3) begin
      st = 1;
    end else if (was_on && c != 4'd0) begin
      m_err = 1;
    end
    if (kl) begin m_act = 0; m_cnt = 0; end
    else if (st) begin m_act = 1; m_cnt = 0; m_src = was_on; m_loc = m_sel; end
    else if (m_act) begin
      if (m_cnt == BL - 1) begin m_act = 0; m_cnt = 0; end
      else m_cnt++;
    end
  endtask

  // One cycle: drive at negedge, check the combinational write strobe, then
  // check all registered outputs just after the following rising edge.
  task automatic step(input logic [3:0] c, input logic [1:0] a, input logic [2:0] b,
                      input bit idle, input bit trp, input string tag);
    logic [DQ_W-1:0] arr;
    @(negedge clk);
    arr        = DQ_W'($urandom);
    cmd_valid  = 1'b1; cmd_code = c; mr_addr = a; mr_bits = b;
    banks_idle = idle; trp_met = trp; array_dq = arr;
    #1;
    check(array_wr_en == exp_wr(c), {tag, " wr_en R8"}, 32'(array_wr_en), 32'(exp_wr(c)));
    model(c, a, b, idle, trp);
    @(posedge clk); #1;
    check(cmd_err == m_err,    {tag, " err"},    32'(cmd_err),    32'(m_err));
    check(mpr_active == m_on,  {tag, " mode"},   32'(mpr_active), 32'(m_on));
    check(rd_valid == m_act,   {tag, " valid"},  32'(rd_valid),   32'(m_act));
    check(dq_out == exp_dq(arr), {tag, " dq"},   32'(dq_out),     32'(exp_dq(arr)));
  endtask

  task automatic nops(input int n, input string tag);
    for (int i = 0; i < n; i++) step(4'd0, 2'd0, 3'd0, 1'b1, 1'b1, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    rst_n = 1'b0; cmd_valid = 0; cmd_code = 0; mr_addr = 0; mr_bits = 0;
    banks_idle = 1; trp_met = 1; array_dq = '1;
    m_on = 0; m_err = 0; m_act = 0; m_src = 0; m_sel = 0; m_loc = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    check(mpr_active == 0 && cmd_err == 0 && rd_valid == 0 && dq_out == '0,
          "R1 reset state", {dq_out, 13'd0, mpr_active, cmd_err, rd_valid},
          32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    nops(2, "R1 after reset");

    // Normal reads and writes.
    step(4'd2, 0, 0, 1, 1, "R7 normal read");
    nops(BL, "R7 burst");
    step(4'd4, 0, 0, 1, 1, "R8 normal write");
    step(4'd5, 0, 0, 1, 1, "R8 activate ok");
    step(4'd7, 0, 0, 0, 0, "R8 refresh ok");
    // Blocked entry.
    step(4'd1, 3, 3'b100, 0, 1, "R3 banks busy");
    step(4'd1, 3, 3'b100, 1, 0, "R3 trp pending");
    // Entry with select 00 and pattern readout.
    step(4'd1, 3, 3'b100, 1, 1, "R2 enter");
    step(4'd2, 0, 0, 1, 1, "R5 mpr read");
    nops(3, "R5 R13 pattern");
    step(4'd4, 0, 0, 1, 1, "R4 write rejected mid-burst");
    step(4'd5, 0, 0, 1, 1, "R4 activate rejected");
    step(4'd6, 0, 0, 1, 1, "R4 precharge rejected");
    step(4'd7, 0, 0, 1, 1, "R4 refresh rejected");
    step(4'd8, 0, 0, 1, 1, "R4 power-down rejected");
    step(4'd9, 0, 0, 1, 1, "R4 self-refresh rejected");
    step(4'd1, 2, 3'b000, 1, 1, "R4 other mode register rejected");
    step(4'd1, 3, 3'b101, 1, 1, "R4 re-enable rejected");
    step(4'd3, 0, 0, 1, 1, "R11 rdap repeat");
    nops(2, "R11 burst");
    step(4'd2, 0, 0, 1, 1, "R11 restart mid-burst");
    nops(3, "R11 burst");
    step(4'd1, 3, 3'b000, 0, 0, "R10 exit mid-burst ignores idle");
    nops(BL, "R12 source kept");
    // Other selects.
    step(4'd1, 3, 3'b110, 1, 1, "R2 enter sel 10");
    step(4'd2, 0, 0, 1, 1, "R6 read sel 10");
    nops(BL, "R6 zero burst");
    step(4'd1, 3, 3'b001, 1, 1, "R10 exit sel 01");
    step(4'd1, 3, 3'b101, 1, 1, "R2 enter sel 01");
    step(4'd2, 0, 0, 1, 1, "R6 read sel 01");
    nops(2, "R6 zero burst");
    step(4'd10, 0, 0, 0, 0, "R9 reset command mid-burst");
    nops(2, "R9 after reset");
    step(4'd2, 0, 0, 1, 1, "R9 R7 reads from array after reset");
    nops(BL, "R7 burst");

    // Constrained random phase.
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] c;
      int r = $urandom_range(0, 99);
      if (r < 30)      c = 4'd2 + 4'($urandom_range(0, 1));
      else if (r < 50) c = 4'd1;
      else if (r < 53) c = 4'd10;
      else             c = 4'($urandom_range(0, 9));
      step(c, ($urandom_range(0, 9) < 8) ? 2'd3 : 2'($urandom),
           3'($urandom), ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0),
           "R11 R12 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule